// File: doc/BRIEF.md
# Clock source mode controller

The controller picks the system clock from three free-running inputs: a locked-loop output, an internal reference and an external reference. It also decides which helper clocks stay on. A source change requested through the select field is handed over without glitches. The outgoing clock is gated off on its own falling edge. The incoming clock is enabled only after a synchronizer in its own domain has seen it toggle. A request for a clock that is flagged absent is refused, and the current source stays in use.

The chosen clock then passes through a power-of-two divider, and a new divide code takes effect at once. The block also drives the enable for the locked loop and a low-speed debug clock enable. The loop is switched off in one low-power bypass condition, and both enables go low in stop. Each reference clock output follows its own enable bit. In stop, a reference clock output keeps running only if its stop-enable bit is also set. A status output shows the source in use and changes only once a handover has finished.

Top module: `clk_mode_ctrl`

## Requirements
- R1: Select code 2'b00 routes the locked-loop clock, 2'b01 the internal reference and 2'b10 the external reference to `sys_clk_o`. After the handover, `active_src_o` equals the code.
- R2: Select code 2'b11 is reserved and leaves the active source and `sys_clk_o` unchanged.
- R3: A source change is committed only after the new clock has toggled through its synchronizer. `active_src_o` still shows the old code two control cycles after the select changes, and it takes the new code only once the handover is complete.
- R4: A request for a source whose availability flag is 0 is refused, and the previous source keeps driving `sys_clk_o`. Once the flag returns to 1, the pending request is honoured.
- R5: At most one source is gated onto the output at any time, and `sys_clk_o` with divide code 0 shows no pulse shorter than half a period of the fastest input.
- R6: Divide codes 0, 1, 2 and 3 give `sys_clk_o` periods of 1, 2, 4 and 8 times the source period, and a new code applies from the next divided edge with no handover.
- R7: `fll_en_o` and `dbg_lclk_en_o` are 0 one control cycle after select = 2'b10, reference select = 0, low-power = 1 and debug inactive all hold together. Otherwise, outside stop, both are 1.
- R8: While `stop_i` is 1, `sys_clk_o` makes no edges, and `fll_en_o` and `dbg_lclk_en_o` are 0. The previous source resumes after stop is released.
- R9: `irc_clk_o` toggles when `irc_en_i` is 1 and either stop is 0 or `irc_stop_en_i` is 1. Otherwise it is held low.
- R10: `erc_clk_o` toggles when `erc_en_i` is 1 and either stop is 0 or `erc_stop_en_i` is 1. Otherwise it is held low.
- R11: After reset, `active_src_o` is 2'b00, and once the first control cycle after reset has passed, `fll_en_o` and `dbg_lclk_en_o` are 1 with all request inputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock for selection logic |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fll_clk_i | input | 1 | Locked-loop output clock |
| irc_clk_i | input | 1 | Internal reference clock |
| erc_clk_i | input | 1 | External reference clock |
| fll_ok_i | input | 1 | Locked-loop clock available |
| irc_ok_i | input | 1 | Internal reference available |
| erc_ok_i | input | 1 | External reference available |
| src_sel_i | input | 2 | Source select code |
| ref_sel_i | input | 1 | Loop reference select (1 internal, 0 external) |
| lp_i | input | 1 | Low-power request |
| dbg_active_i | input | 1 | Debug session active |
| stop_i | input | 1 | Stop state |
| irc_en_i | input | 1 | Internal reference output enable |
| irc_stop_en_i | input | 1 | Internal reference stays on in stop |
| erc_en_i | input | 1 | External reference output enable |
| erc_stop_en_i | input | 1 | External reference stays on in stop |
| bus_div_i | input | 2 | Bus divide code |
| sys_clk_o | output | 1 | Divided system clock |
| fll_en_o | output | 1 | Locked-loop enable |
| dbg_lclk_en_o | output | 1 | Debug low-speed clock enable |
| irc_clk_o | output | 1 | Gated internal reference clock |
| erc_clk_o | output | 1 | Gated external reference clock |
| active_src_o | output | 2 | Source code currently in use |

## Verification
On every control cycle the assertions check several properties. Source gates stay one-hot or off. A committed target always had its availability flag set. The status output only ever moves to the committed target. The loop and debug enables obey the bypass and stop rules. Only the bench scenarios can show the clocking effects: the measured output period for each source and divide code, the lag of the status behind the select, the absence of runt pulses across handovers, silence of the output in stop, and the reference gating under every combination of enable, stop-enable and stop.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_FLL = 2'b00,
    SRC_IRC = 2'b01,
    SRC_ERC = 2'b10,
    SRC_RSV = 2'b11
  } src_e;
endpackage

// File: rtl/src_gate_sync.sv
// Per-source enable synchronizer on falling edges; gate changes only while clock is low.
module src_gate_sync #(
  parameter int STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic en_o,
  output logic gclk_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], req_i};
  end

  assign en_o   = sh_q[STAGES-1];
  assign gclk_o = clk_i & en_o;
endmodule

// File: rtl/ref_clk_gate.sv
module ref_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  output logic clk_o
);
  logic on_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) on_q <= 1'b0;
    else         on_q <= on_i;
  end

  assign clk_o = clk_i & on_q;
endmodule

// File: rtl/bus_div.sv
// Free-running ripple taps; code selects tap directly so a new code applies at once.
module bus_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   taps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign taps  = {cnt_q, clk_i};
  assign clk_o = taps[div_i];
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 3,
  parameter int BACK_STAGES = 2,
  parameter int DIV_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fll_clk_i,
  input  logic             irc_clk_i,
  input  logic             erc_clk_i,
  input  logic             fll_ok_i,
  input  logic             irc_ok_i,
  input  logic             erc_ok_i,
  input  logic [1:0]       src_sel_i,
  input  logic             ref_sel_i,
  input  logic             lp_i,
  input  logic             dbg_active_i,
  input  logic             stop_i,
  input  logic             irc_en_i,
  input  logic             irc_stop_en_i,
  input  logic             erc_en_i,
  input  logic             erc_stop_en_i,
  input  logic [DIV_W-1:0] bus_div_i,
  output logic             sys_clk_o,
  output logic             fll_en_o,
  output logic             dbg_lclk_en_o,
  output logic             irc_clk_o,
  output logic             erc_clk_o,
  output logic [1:0]       active_src_o
);
  logic [NUM_SRC-1:0] src_clk;
  logic [NUM_SRC-1:0] src_req;
  logic [NUM_SRC-1:0] src_en;
  logic [NUM_SRC-1:0] src_gclk;
  logic [NUM_SRC-1:0] en_sync_q [BACK_STAGES];
  logic [NUM_SRC:0]   avail_v;
  src_e               tgt_q;
  src_e               active_q;
  logic               mux_clk;
  logic               bypass_lp;
  logic               fll_en_q;
  logic               dbg_en_q;

  assign src_clk = {erc_clk_i, irc_clk_i, fll_clk_i};
  assign avail_v = {1'b0, erc_ok_i, irc_ok_i, fll_ok_i};

  function automatic logic [NUM_SRC-1:0] src_onehot(src_e s);
    return NUM_SRC'(1) << s;
  endfunction

  // Source gates: request only once every other gate reports off.
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign src_req[k] = (tgt_q == src_e'(k)) && !stop_i &&
                        !(|(src_en & ~(NUM_SRC'(1) << k)));
    src_gate_sync #(.STAGES(SYNC_STAGES)) u_gate (
      .clk_i  (src_clk[k]),
      .rst_ni (rst_ni),
      .req_i  (src_req[k]),
      .en_o   (src_en[k]),
      .gclk_o (src_gclk[k])
    );
  end

  assign mux_clk = |src_gclk;

  // Bring gate states back into the control domain.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BACK_STAGES; i++) en_sync_q[i] <= '0;
    end else begin
      en_sync_q[0] <= src_en;
      for (int i = 1; i < BACK_STAGES; i++) en_sync_q[i] <= en_sync_q[i-1];
    end
  end

  // Target accepted only when idle; status follows when the new gate is seen alone.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q    <= SRC_FLL;
      active_q <= SRC_FLL;
    end else if (tgt_q == active_q) begin
      if (src_sel_i != SRC_RSV && src_sel_i != tgt_q &&
          avail_v[src_sel_i] && !stop_i)
        tgt_q <= src_e'(src_sel_i);
    end else if (en_sync_q[BACK_STAGES-1] == src_onehot(tgt_q)) begin
      active_q <= tgt_q;
    end
  end

  assign bypass_lp = (src_sel_i == SRC_ERC) && !ref_sel_i && lp_i && !dbg_active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fll_en_q <= 1'b0;
      dbg_en_q <= 1'b0;
    end else begin
      fll_en_q <= !bypass_lp && !stop_i;
      dbg_en_q <= !bypass_lp && !stop_i;
    end
  end

  bus_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (mux_clk),
    .rst_ni (rst_ni),
    .div_i  (bus_div_i),
    .clk_o  (sys_clk_o)
  );

  ref_clk_gate u_irc_gate (
    .clk_i  (irc_clk_i),
    .rst_ni (rst_ni),
    .on_i   (irc_en_i && (!stop_i || irc_stop_en_i)),
    .clk_o  (irc_clk_o)
  );

  ref_clk_gate u_erc_gate (
    .clk_i  (erc_clk_i),
    .rst_ni (rst_ni),
    .on_i   (erc_en_i && (!stop_i || erc_stop_en_i)),
    .clk_o  (erc_clk_o)
  );

  assign fll_en_o      = fll_en_q;
  assign dbg_lclk_en_o = dbg_en_q;
  assign active_src_o  = active_q;
endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] src_en,
  input logic [1:0] tgt_q,
  input logic [1:0] active_src_o,
  input logic [3:0] avail_v,
  input logic [1:0] src_sel_i,
  input logic       ref_sel_i,
  input logic       lp_i,
  input logic       dbg_active_i,
  input logic       stop_i,
  input logic       fll_en_o,
  input logic       dbg_lclk_en_o
);
  AST_ONE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_en)); // R5

  AST_TGT_AVAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_q != $past(tgt_q)) |-> (|($past(avail_v) & (4'b1 << tgt_q)))); // R4

  AST_STATUS_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_src_o != $past(active_src_o)) |-> (active_src_o == $past(tgt_q))); // R3

  AST_NO_RSV_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 2'b11) |=> (tgt_q == $past(tgt_q))); // R2

  AST_BYPASS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 2'b10 && !ref_sel_i && lp_i && !dbg_active_i)
      |=> (!fll_en_o && !dbg_lclk_en_o)); // R7

  AST_STOP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!fll_en_o && !dbg_lclk_en_o)); // R8
endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .src_en        (src_en),
  .tgt_q         (tgt_q),
  .active_src_o  (active_src_o),
  .avail_v       (avail_v),
  .src_sel_i     (src_sel_i),
  .ref_sel_i     (ref_sel_i),
  .lp_i          (lp_i),
  .dbg_active_i  (dbg_active_i),
  .stop_i        (stop_i),
  .fll_en_o      (fll_en_o),
  .dbg_lclk_en_o (dbg_lclk_en_o)
);

// File: tb/tb_clk_mode_ctrl.sv
`timescale 1ns/1ps
module tb_clk_mode_ctrl;
  logic clk = 0, rst_ni = 0;
  logic fll_clk = 0, irc_clk = 0, erc_clk = 0;
  logic fll_ok = 1, irc_ok = 1, erc_ok = 1;
  logic [1:0] src_sel = 0;
  logic ref_sel = 0, lp = 0, dbg = 0, stop = 0;
  logic irc_en = 0, irc_sten = 0, erc_en = 0, erc_sten = 0;
  logic [1:0] bus_div = 0;
  logic sys_clk, fll_en, dbg_en, irc_out, erc_out;
  logic [1:0] active;

  always #4 clk = ~clk;
  always #3 fll_clk = ~fll_clk;
  always #10 irc_clk = ~irc_clk;
  always #7 erc_clk = ~erc_clk;

  clk_mode_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .fll_clk_i(fll_clk), .irc_clk_i(irc_clk), .erc_clk_i(erc_clk),
    .fll_ok_i(fll_ok), .irc_ok_i(irc_ok), .erc_ok_i(erc_ok),
    .src_sel_i(src_sel), .ref_sel_i(ref_sel), .lp_i(lp), .dbg_active_i(dbg),
    .stop_i(stop), .irc_en_i(irc_en), .irc_stop_en_i(irc_sten),
    .erc_en_i(erc_en), .erc_stop_en_i(erc_sten), .bus_div_i(bus_div),
    .sys_clk_o(sys_clk), .fll_en_o(fll_en), .dbg_lclk_en_o(dbg_en),
    .irc_clk_o(irc_out), .erc_clk_o(erc_out), .active_src_o(active)
  );

  int errors = 0, checks = 0;
  int sys_cnt = 0, irc_cnt = 0, erc_cnt = 0;
  int src_ps [3] = '{6000, 20000, 14000};
  bit mon_en = 0;
  real last_t = 0.0, min_pw = 1.0e9;

  always @(posedge sys_clk) sys_cnt++;
  always @(posedge irc_out) irc_cnt++;
  always @(posedge erc_out) erc_cnt++;
  always @(sys_clk) begin
    if (mon_en && ($realtime - last_t) < min_pw) min_pw = $realtime - last_t;
    last_t = $realtime;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic measure(output int ps);
    real t0;
    @(posedge sys_clk);
    @(posedge sys_clk);
    t0 = $realtime;
    @(posedge sys_clk);
    ps = int'(($realtime - t0) * 1000.0);
  endtask

  task automatic wait_active(input logic [1:0] exp);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (active == exp) break;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int per, c0, c1, c2;
    logic [1:0] prev;
    repeat (5) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check(active == 2'b00, "R11", "status after reset", active, 0);
    repeat (2) @(negedge clk);
    check(fll_en == 1 && dbg_en == 1, "R11", "enables after reset", {fll_en, dbg_en}, 3);

    // R1 / R6 / R3: every source against every divide code
    prev = 2'b00;
    for (int s = 0; s < 3; s++) begin
      src_sel = 2'(s);
      if (s != 0) begin
        repeat (2) @(negedge clk);
        check(active == prev, "R3", "status lags select", active, prev);
      end
      wait_active(2'(s));
      check(active == 2'(s), "R1", "status after handover", active, s);
      for (int d = 0; d < 4; d++) begin
        bus_div = 2'(d);
        measure(per);
        check(per == (src_ps[s] << d), "R6", "divided period", per, src_ps[s] << d);
      end
      bus_div = 0;
      prev = 2'(s);
    end

    // R2: reserved code keeps external reference
    src_sel = 2'b11;
    repeat (100) @(negedge clk);
    check(active == 2'b10, "R2", "status on reserved", active, 2);
    measure(per);
    check(per == 14000, "R2", "period on reserved", per, 14000);

    // R5: handovers at divide 1 show no runt pulse
    min_pw = 1.0e9;
    mon_en = 1;
    src_sel = 2'b00; wait_active(2'b00);
    src_sel = 2'b01; wait_active(2'b01);
    src_sel = 2'b10; wait_active(2'b10);
    src_sel = 2'b00; wait_active(2'b00);
    repeat (10) @(negedge clk);
    mon_en = 0;
    check(min_pw >= 2.999, "R5", "min pulse width ps", int'(min_pw * 1000.0), 3000);

    // R4: absent external reference refused, then honoured
    erc_ok = 0;
    src_sel = 2'b10;
    repeat (200) @(negedge clk);
    check(active == 2'b00, "R4", "status on refused source", active, 0);
    measure(per);
    check(per == 6000, "R4", "period on refused source", per, 6000);
    erc_ok = 1;
    wait_active(2'b10);
    check(active == 2'b10, "R4", "status once available", active, 2);

    // R8: stop silences system clock and enables
    stop = 1;
    repeat (40) @(negedge clk);
    c0 = sys_cnt;
    repeat (60) @(negedge clk);
    check(sys_cnt == c0, "R8", "edges in stop", sys_cnt - c0, 0);
    check(fll_en == 0 && dbg_en == 0, "R8", "enables in stop", {fll_en, dbg_en}, 0);
    stop = 0;
    repeat (40) @(negedge clk);
    measure(per);
    check(per == 14000, "R8", "period after stop", per, 14000);

    // R9 / R10: reference gating sweep
    for (int i = 0; i < 8; i++) begin
      bit en, sten, stp, run;
      en = i[0]; sten = i[1]; stp = i[2];
      irc_en = en; irc_sten = sten; erc_en = en; erc_sten = sten; stop = stp;
      run = en && (!stp || sten);
      repeat (15) @(negedge clk);
      c1 = irc_cnt; c2 = erc_cnt;
      repeat (50) @(negedge clk);
      check((irc_cnt > c1) == run, "R9", "internal ref running", irc_cnt - c1, run);
      check((erc_cnt > c2) == run, "R10", "external ref running", erc_cnt - c2, run);
    end
    stop = 0;
    repeat (40) @(negedge clk);

    // R7: loop enable across select, reference, low-power and debug
    for (int i = 0; i < 32; i++) begin
      bit e;
      src_sel = 2'(i & 3); ref_sel = i[2]; lp = i[3]; dbg = i[4];
      repeat (2) @(negedge clk);
      e = !((i & 3) == 2 && !i[2] && i[3] && !i[4]);
      check(fll_en == e, "R7", "loop enable", fll_en, e);
      check(dbg_en == e, "R7", "debug clock enable", dbg_en, e);
    end

    summary();
    $finish;
  end
endmodule